// File: doc/BRIEF.md
# Burst Data-Phase Sequencer for a Multiplexed-Bus Initiator

This block sequences the data phases of a burst on a 32-bit multiplexed address/data bus, seen from the initiator side. It is started once the address phase has been issued. It then holds the frame line asserted, waits until the target claims the cycle with device-select, and carries one word per data phase. Each phase completes only on a clock where both its own initiator-ready and the target's target-ready are low. It stops when the requested number of words has moved.

The local side gives a start pulse, a direction bit and a word count. It then supplies one entry per data phase on a valid/ready stream. Each entry carries active-low byte enables, plus the data word for writes; on reads the data field of the entry is ignored. Read words come back on a one-cycle valid output.

The design is one state machine with four states:
- `ST_IDLE`: no burst in progress.
- `ST_SEL`: frame is asserted and the engine waits for device-select.
- `ST_FETCH`: the engine waits for a local entry, with initiator-ready high.
- `ST_HOLD`: initiator-ready is asserted and the engine waits for target-ready.

Transitions:
- IDLE→SEL on an accepted start.
- SEL→HOLD when device-select is low and an entry is offered; SEL→FETCH when device-select is low and no entry is offered.
- FETCH→HOLD when an entry is taken.
- HOLD→HOLD when a non-final phase completes and the next entry is taken in the same clock.
- HOLD→FETCH when a non-final phase completes and no entry is offered.
- HOLD→IDLE when the final phase completes.

Top module: `burst_phase_engine`

## Requirements
- R1: A start pulse with a nonzero count asserts `bus_frame_n` (driven 0) on the next clock. Initiator-ready is never asserted before a clock on which `bus_devsel_n` was sampled low. A start pulse with count 0 is ignored: frame and initiator-ready stay 1 and no local entry is accepted.
- R2: Initiator-ready is asserted only for a phase whose local entry has been accepted. While the stream has no entry, initiator-ready stays 1 (wait states). Exactly count entries are accepted per burst.
- R3: While `bus_irdy_n` is 0 and `bus_trdy_n` is 1, on the next clock `bus_irdy_n` is still 0 and `bus_cbe_n` and `bus_ad_out` are unchanged.
- R4: A word moves only on a clock where both `bus_irdy_n` and `bus_trdy_n` are 0. Exactly count words move per burst. Each phase drives `bus_cbe_n` equal to its entry's `loc_be_n`, where bit i at 0 enables byte i. The value 4'hF is issued and counted like any other phase.
- R5: `bus_frame_n` goes to 1 on the same clock on which initiator-ready is asserted for the final phase, and it stays 1 through that phase.
- R6: On the clock after the final phase completes, `bus_irdy_n` is 1, `bus_ad_oe` is 0 and `bus_cbe_n` is 4'hF.
- R7: In a write burst, `bus_ad_oe` is 1 and `bus_ad_out` holds the phase's word whenever initiator-ready is asserted. In a read burst, `bus_ad_oe` is never 1.
- R8: In a read burst, `rd_valid` is 1 for one clock right after each completing clock. `rd_data` then equals `bus_ad_in` as sampled on the completing clock. Otherwise `rd_valid` is 0.
- R9: With target-ready held low and an entry always offered, initiator-ready stays low for exactly count consecutive clocks, so one word moves per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse, taken in idle |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_count | input | CNT_W | Number of data phases; 0 is ignored |
| loc_valid | input | 1 | Local phase entry offered |
| loc_ready | output | 1 | Local phase entry accepted this clock |
| loc_data | input | DATA_W | Write word of the entry |
| loc_be_n | input | DATA_W/8 | Active-low byte enables of the entry |
| rd_valid | output | 1 | Read word available |
| rd_data | output | DATA_W | Read word |
| bus_frame_n | output | 1 | Frame, active low |
| bus_irdy_n | output | 1 | Initiator ready, active low |
| bus_trdy_n | input | 1 | Target ready, active low |
| bus_devsel_n | input | 1 | Device select, active low |
| bus_cbe_n | output | DATA_W/8 | Byte enables, active low |
| bus_ad_out | output | DATA_W | Address/data value driven out |
| bus_ad_oe | output | 1 | Output enable for the AD lines |
| bus_ad_in | input | DATA_W | Address/data value sampled in |

## Verification
The bench builds the engine with CNT_W = 3 and DATA_W = 32, so every legal count from 1 to 7 can be swept, along with the ignored count of 0. Each count is run in both directions, with three target wait patterns (none, sparse, dense), three device-select delays and two local-stream patterns (steady and gappy). This reaches every state transition, including HOLD→FETCH starvation and the final phase being the first phase. The all-disabled byte-enable phase is covered as well, and the no-wait sweeps measure full-rate bursting directly.

// File: rtl/bpe_pkg.sv
package bpe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEL   = 2'd1,
        ST_FETCH = 2'd2,
        ST_HOLD  = 2'd3
    } bpe_state_e;
endpackage

// File: rtl/bpe_beat_counter.sv
module bpe_beat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_one,
    output logic             is_two
);
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec && left_q != '0) begin
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign is_one = (left_q == CNT_W'(1));
    assign is_two = (left_q == CNT_W'(2));
endmodule

// File: rtl/bpe_read_capture.sv
module bpe_read_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              beat_done,
    input  logic              is_read,
    input  logic [DATA_W-1:0] ad_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word_q;
    logic              vld_q;

    // The AD lines are latched on every clock of a phase; only the
    // value taken on the completing clock is flagged as valid.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            if (sample_en) begin
                word_q <= ad_in;
            end
            vld_q <= beat_done && is_read;
        end
    end

    assign rd_valid = vld_q;
    assign rd_data  = word_q;
endmodule

// File: rtl/burst_phase_engine.sv
module burst_phase_engine
    import bpe_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int CNT_W  = 4,
    localparam int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_write,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              loc_valid,
    output logic              loc_ready,
    input  logic [DATA_W-1:0] loc_data,
    input  logic [BE_W-1:0]   loc_be_n,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_frame_n,
    output logic              bus_irdy_n,
    input  logic              bus_trdy_n,
    input  logic              bus_devsel_n,
    output logic [BE_W-1:0]   bus_cbe_n,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in
);
    bpe_state_e state_q, state_d;

    logic              frame_n_q;
    logic              irdy_n_q;
    logic [BE_W-1:0]   cbe_n_q;
    logic [DATA_W-1:0] ad_q;
    logic              oe_q;
    logic              dir_q;

    logic go;
    logic beat_done;
    logic take;
    logic is_one;
    logic is_two;
    logic next_final;

    assign go        = (state_q == ST_IDLE) && cmd_start && (cmd_count != '0);
    assign beat_done = (state_q == ST_HOLD) && !irdy_n_q && !bus_trdy_n;

    always_comb begin
        loc_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:  loc_ready = 1'b0;
            ST_SEL:   loc_ready = !bus_devsel_n;
            ST_FETCH: loc_ready = 1'b1;
            ST_HOLD:  loc_ready = beat_done && !is_one;
        endcase
    end

    assign take = loc_ready && loc_valid;

    // The entry being loaded is the final one when one word is left
    // (from SEL/FETCH) or two are left while one completes (from HOLD).
    assign next_final = (state_q == ST_HOLD) ? is_two : is_one;

    bpe_beat_counter #(
        .CNT_W(CNT_W)
    ) i_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (go),
        .load_val(cmd_count),
        .dec     (beat_done),
        .is_one  (is_one),
        .is_two  (is_two)
    );

    bpe_read_capture #(
        .DATA_W(DATA_W)
    ) i_rcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_en(state_q == ST_HOLD),
        .beat_done(beat_done),
        .is_read  (!dir_q),
        .ad_in    (bus_ad_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ST_SEL;
            end
            ST_SEL: begin
                if (!bus_devsel_n) state_d = take ? ST_HOLD : ST_FETCH;
            end
            ST_FETCH: begin
                if (take) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (beat_done) begin
                    if (is_one)    state_d = ST_IDLE;
                    else if (take) state_d = ST_HOLD;
                    else           state_d = ST_FETCH;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_n_q <= 1'b1;
            irdy_n_q  <= 1'b1;
            cbe_n_q   <= '1;
            ad_q      <= '0;
            oe_q      <= 1'b0;
            dir_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        frame_n_q <= 1'b0;
                        dir_q     <= cmd_write;
                        cbe_n_q   <= '1;
                    end
                end
                ST_SEL, ST_FETCH: begin
                    if (take) begin
                        irdy_n_q  <= 1'b0;
                        cbe_n_q   <= loc_be_n;
                        ad_q      <= loc_data;
                        oe_q      <= dir_q;
                        frame_n_q <= next_final;
                    end
                end
                ST_HOLD: begin
                    if (beat_done) begin
                        if (is_one) begin
                            irdy_n_q <= 1'b1;
                            oe_q     <= 1'b0;
                            cbe_n_q  <= '1;
                        end else if (take) begin
                            cbe_n_q   <= loc_be_n;
                            ad_q      <= loc_data;
                            frame_n_q <= next_final;
                        end else begin
                            irdy_n_q <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign bus_frame_n = frame_n_q;
    assign bus_irdy_n  = irdy_n_q;
    assign bus_cbe_n   = cbe_n_q;
    assign bus_ad_out  = ad_q;
    assign bus_ad_oe   = oe_q;
endmodule

// File: rtl/bpe_checker.sv
module bpe_checker #(
    parameter int DATA_W = 32,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irdy_n,
    input logic              trdy_n,
    input logic              frame_n,
    input logic [BE_W-1:0]   cbe_n,
    input logic [DATA_W-1:0] ad_out,
    input logic              ad_oe,
    input logic              rd_valid,
    input logic              dir_wr
);
    assert_hold_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && trdy_n) |=> (!irdy_n && $stable(cbe_n) && $stable(ad_out)));

    assert_frame_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_n) |-> !irdy_n);

    assert_end_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && !trdy_n && frame_n) |=> (irdy_n && !ad_oe));

    assert_read_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_wr) |-> !ad_oe);

    assert_read_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!irdy_n && !trdy_n));
endmodule

bind burst_phase_engine bpe_checker #(
    .DATA_W(DATA_W),
    .BE_W  (BE_W)
) i_bpe_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .irdy_n  (bus_irdy_n),
    .trdy_n  (bus_trdy_n),
    .frame_n (bus_frame_n),
    .cbe_n   (bus_cbe_n),
    .ad_out  (bus_ad_out),
    .ad_oe   (bus_ad_oe),
    .rd_valid(rd_valid),
    .dir_wr  (dir_q)
);

// File: tb/test_burst_phase_engine.sv
`timescale 1ns/1ps
module test_burst_phase_engine;
    localparam int DW = 32;
    localparam int CW = 3;
    localparam int BW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic          cmd_write = 1'b0;
    logic [CW-1:0] cmd_count = '0;
    logic          loc_valid = 1'b0;
    logic          loc_ready;
    logic [DW-1:0] loc_data = '0;
    logic [BW-1:0] loc_be_n = '1;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          bus_frame_n;
    logic          bus_irdy_n;
    logic          bus_trdy_n = 1'b1;
    logic          bus_devsel_n = 1'b1;
    logic [BW-1:0] bus_cbe_n;
    logic [DW-1:0] bus_ad_out;
    logic          bus_ad_oe;
    logic [DW-1:0] bus_ad_in = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    burst_phase_engine #(.DATA_W(DW), .CNT_W(CW)) i_burst_phase_engine (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_write(cmd_write),
        .cmd_count(cmd_count), .loc_valid(loc_valid), .loc_ready(loc_ready),
        .loc_data(loc_data), .loc_be_n(loc_be_n), .rd_valid(rd_valid),
        .rd_data(rd_data), .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n),
        .bus_trdy_n(bus_trdy_n), .bus_devsel_n(bus_devsel_n), .bus_cbe_n(bus_cbe_n),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in)
    );

    function automatic logic [DW-1:0] wpat(int k);
        return 32'hC0DE_0000 + 32'(k) * 32'h0001_0203;
    endfunction
    function automatic logic [DW-1:0] rpat(int k);
        return 32'h5A00_0000 + 32'(k) * 32'h0000_1111;
    endfunction
    function automatic logic [BW-1:0] bpat(int k);
        return (k == 2) ? 4'hF : 4'(k * 3 + 1);
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_burst(input bit wr, input int cnt, input int wmode,
                             input int dsel, input int vmode);
        int  k = 0;
        int  used = 0;
        int  c = 0;
        int  irdy_cycles = 0;
        bit  sel_seen = 0;
        bit  prev_hold = 0;
        bit  prev_xfer = 0;
        int  prev_k = 0;
        logic [BW-1:0] prev_cbe = '0;
        logic [DW-1:0] prev_ad = '0;
        bit  take;
        bit  xfer;
        @(negedge clk);
        cmd_start = 1'b1; cmd_write = wr; cmd_count = CW'(cnt);
        @(negedge clk);
        cmd_start = 1'b0;
        while (k < cnt && c < 2000) begin
            if (c == 0)
                check(bus_frame_n == 0 && bus_irdy_n == 1, "R1 frame on start",
                      {bus_frame_n, bus_irdy_n}, 2'b01);
            if (prev_hold)
                check(bus_irdy_n == 0 && bus_cbe_n == prev_cbe && bus_ad_out == prev_ad,
                      "R3 hold", {bus_irdy_n, bus_cbe_n}, {1'b0, prev_cbe});
            if (!wr)
                check(rd_valid == prev_xfer && (!prev_xfer || rd_data == rpat(prev_k)),
                      "R8 read word", {rd_valid, rd_data}, {prev_xfer, rpat(prev_k)});
            if (bus_irdy_n == 0) begin
                irdy_cycles++;
                check(sel_seen, "R1 irdy after devsel", sel_seen, 1);
                check(bus_ad_oe == wr, "R7 drive enable", bus_ad_oe, wr);
                check(k < used, "R2 entry before irdy", k, used);
            end
            prev_hold = (bus_irdy_n == 0);
            prev_cbe  = bus_cbe_n;
            prev_ad   = bus_ad_out;
            bus_devsel_n = (c >= dsel) ? 1'b0 : 1'b1;
            step_lfsr();
            if (bus_devsel_n) bus_trdy_n = 1'b1;
            else if (wmode == 0) bus_trdy_n = 1'b0;
            else if (wmode == 1) bus_trdy_n = lfsr[0] & lfsr[3];
            else bus_trdy_n = lfsr[1] | lfsr[4];
            bus_ad_in = bus_trdy_n ? {lfsr, lfsr} : rpat(k);
            loc_valid = (used < cnt) && (vmode == 0 || lfsr[7] || lfsr[9]);
            loc_data  = wpat(used);
            loc_be_n  = bpat(used);
            #1;
            take = loc_valid && loc_ready;
            xfer = (bus_irdy_n == 0) && (bus_trdy_n == 0);
            if (bus_devsel_n == 0) sel_seen = 1;
            if (xfer) begin
                check(bus_cbe_n == bpat(k), "R4 byte enables", bus_cbe_n, bpat(k));
                check(bus_frame_n == (k == cnt - 1), "R5 frame on final",
                      bus_frame_n, (k == cnt - 1));
                if (wr) check(bus_ad_out == wpat(k), "R7 write word", bus_ad_out, wpat(k));
                prev_k = k;
                k++;
                prev_hold = 0;
            end
            prev_xfer = xfer;
            if (take) used++;
            @(negedge clk);
            c++;
        end
        if (c >= 2000) check(0, "R4 burst stalled", k, cnt);
        check(bus_irdy_n == 1 && bus_ad_oe == 0 && bus_cbe_n == 4'hF && bus_frame_n == 1,
              "R6 release", {bus_irdy_n, bus_ad_oe, bus_cbe_n, bus_frame_n}, 7'b1011111);
        if (!wr)
            check(rd_valid == 1 && rd_data == rpat(cnt - 1), "R8 last read",
                  rd_data, rpat(cnt - 1));
        check(k == cnt, "R4 word count", k, cnt);
        check(used == cnt, "R2 entries taken", used, cnt);
        if (wmode == 0 && vmode == 0)
            check(irdy_cycles == cnt, "R9 full rate", irdy_cycles, cnt);
        bus_devsel_n = 1'b1; bus_trdy_n = 1'b1; loc_valid = 1'b0;
    endtask

    task automatic zero_count();
        bit took = 0;
        @(negedge clk);
        cmd_start = 1'b1; cmd_write = 1'b1; cmd_count = '0;
        loc_valid = 1'b1; bus_devsel_n = 1'b0;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            if (loc_ready) took = 1;
            check(bus_frame_n == 1 && bus_irdy_n == 1, "R1 zero count ignored",
                  {bus_frame_n, bus_irdy_n}, 2'b11);
            @(negedge clk);
        end
        check(!took, "R1 zero count takes no entry", took, 0);
        loc_valid = 1'b0; bus_devsel_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(bus_frame_n == 1 && bus_irdy_n == 1 && bus_ad_oe == 0 && rd_valid == 0,
              "R6 reset state", {bus_frame_n, bus_irdy_n, bus_ad_oe, rd_valid}, 4'b1100);
        rst_n = 1'b1;
        zero_count();
        for (int wr = 0; wr < 2; wr++)
            for (int cnt = 1; cnt < (1 << CW); cnt++)
                for (int wm = 0; wm < 3; wm++)
                    for (int ds = 0; ds < 3; ds++)
                        for (int vm = 0; vm < 2; vm++)
                            run_burst(wr[0], cnt, wm, ds, vm);
        zero_count();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule